// File: doc/BRIEF.md
# Programmable Clock Output Divider

This block drives a square-wave clock onto one output pin. It derives that clock from the oscillator clock through a binary prescaler. A single 8-bit control register on a simple register bus sets the ratio and the output enable. The register has one bit that turns the output on and a 4-bit code that picks one prescaler tap.

The main clock feeding the prescaler runs at one of two rates, chosen by a mode-select input: the full oscillator rate, or half of it. Everything runs in the oscillator clock domain. The main clock and every prescaler stage are clock enables, and the output pin comes from registers. A tap with half-period of one main tick therefore gives the fastest output. The enable is resynchronised to the selected tap, so the output only starts or stops during a low phase. This means no pulse on the pin is ever shortened.

Software first programs the ratio code with the enable clear. It then sets the enable in a second write. Before it changes the ratio, it clears the enable.

Top module: `clkout_divider`

## Requirements
- R1: After reset the control register reads 8'h00 and `clk_out` is low.
- R2: The control register sits at bus address 16'hFF40. A write there stores bit 7 (enable) and bits 3:0 (ratio code), and a read there returns them. A read at any other address returns 8'h00, and a write at any other address changes nothing.
- R3: Bits 6:4 of the control register always read as zero, and writes to them are ignored.
- R4: With `mode_full` = 1 the main clock ticks on every oscillator cycle. With `mode_full` = 0 it ticks on every second oscillator cycle.
- R5: Ratio code c in 5..12 selects prescaler tap c-5. When enabled, `clk_out` is a square wave with high and low phases each lasting 2^(c-5) main ticks.
- R6: Ratio codes 0..4 and 13..15 are prohibited and hold `clk_out` low whatever the enable bit is.
- R7: With the enable bit at 0, `clk_out` stays low once it is low.
- R8: The output starts and stops only on a low phase of the selected tap. The first high pulse after enabling and the last high pulse before disabling both have full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_full | input | 1 | 1: main clock = oscillator rate; 0: half oscillator rate |
| bus_addr | input | 16 | Register bus address |
| bus_wr | input | 1 | Register bus write strobe |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data (combinational) |
| clk_out | output | 1 | Divided clock output pin |

## Verification
The hardest case to reach from the ports is a disable write that lands inside a high phase. It is the only way to show that the gate waits for the low phase instead of cutting the pulse. The bench detects a rising edge on the pin and issues the disable write two cycles into the high phase. It then measures the length of that pulse against the full half-period. A monitor running off the falling clock edge records every high and low run on the pin. This gives phase-independent period checks for each vector of the table, covering both main-clock modes.

// File: rtl/clkout_pkg.sv
`timescale 1ns/1ps
package clkout_pkg;

  localparam int CODE_W = 4;

  typedef struct packed {
    logic              en;
    logic [CODE_W-1:0] code;
  } ctrl_t;

endpackage

// File: rtl/clkout_regs.sv
`timescale 1ns/1ps
module clkout_regs
  import clkout_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hFF40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output ctrl_t             ctrl
);

  localparam int EN_BIT = DATA_W - 1;
  localparam int PAD_W  = DATA_W - 1 - CODE_W;

  logic  hit;
  logic  wr_en;
  ctrl_t ctrl_d;
  ctrl_t ctrl_q;
  logic  unused_rsvd;

  assign hit   = (addr == CTRL_ADDR);
  assign wr_en = wr & hit;
  assign unused_rsvd = ^wdata[EN_BIT-1:CODE_W];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d.en   = wdata[EN_BIT];
      ctrl_d.code = wdata[CODE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit) begin
      rdata = {ctrl_q.en, {PAD_W{1'b0}}, ctrl_q.code};
    end
  end

  assign ctrl = ctrl_q;

  assert_write_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctrl_q.en == $past(wdata[EN_BIT])) && (ctrl_q.code == $past(wdata[CODE_W-1:0])));

  assert_foreign_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !hit) |=> $stable(ctrl_q));

endmodule

// File: rtl/clkout_prescaler.sv
`timescale 1ns/1ps
module clkout_prescaler #(
  parameter int STAGES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_full,
  output logic [STAGES-1:0] cnt
);

  logic              half_q;
  logic              half_d;
  logic              tick;
  logic [STAGES-1:0] cnt_q;
  logic [STAGES-1:0] cnt_d;

  always_comb begin
    half_d = ~half_q;
    tick   = mode_full | half_q;
    cnt_d  = cnt_q;
    if (tick) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      half_q <= half_d;
      cnt_q  <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  assert_half_rate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !mode_full) |=> (!tick || mode_full));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

endmodule

// File: rtl/clkout_gate.sv
`timescale 1ns/1ps
module clkout_gate
  import clkout_pkg::*;
#(
  parameter int STAGES    = 8,
  parameter int CODE_BASE = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAGES-1:0] cnt,
  input  ctrl_t             ctrl,
  output logic              clk_out
);

  localparam int TAP_W = (STAGES > 1) ? $clog2(STAGES) : 1;
  localparam logic [CODE_W-1:0] CODE_LO = CODE_W'(CODE_BASE);
  localparam logic [CODE_W-1:0] CODE_HI = CODE_W'(CODE_BASE + STAGES - 1);

  logic             legal;
  logic [TAP_W-1:0] idx;
  logic             tap;
  logic             gate_d;
  logic             gate_q;

  always_comb begin
    legal  = (ctrl.code >= CODE_LO) && (ctrl.code <= CODE_HI);
    idx    = legal ? TAP_W'(ctrl.code - CODE_LO) : '0;
    tap    = legal & cnt[idx];
    gate_d = tap ? gate_q : (ctrl.en & legal);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate_d;
    end
  end

  assign clk_out = gate_q & tap;

  assert_gate_low_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gate_q) |-> !$past(tap));

  assert_disabled_stays_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.en && !clk_out) |=> !clk_out);

endmodule

// File: rtl/clkout_divider.sv
`timescale 1ns/1ps
module clkout_divider
  import clkout_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 16'hFF40,
  parameter int STAGES    = 8,
  parameter int CODE_BASE = 5
) (
  input  logic              osc_clk,
  input  logic              rst_n,
  input  logic              mode_full,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              clk_out
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_int_n;
  ctrl_t                  ctrl;
  logic [STAGES-1:0]      cnt;

  always_ff @(posedge osc_clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_int_n = rst_pipe_q[SYNC_STAGES-1];

  clkout_regs #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CTRL_ADDR (CTRL_ADDR)
  ) i_regs (
    .clk   (osc_clk),
    .rst_n (rst_int_n),
    .addr  (bus_addr),
    .wr    (bus_wr),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .ctrl  (ctrl)
  );

  clkout_prescaler #(
    .STAGES (STAGES)
  ) i_prescaler (
    .clk       (osc_clk),
    .rst_n     (rst_int_n),
    .mode_full (mode_full),
    .cnt       (cnt)
  );

  clkout_gate #(
    .STAGES    (STAGES),
    .CODE_BASE (CODE_BASE)
  ) i_gate (
    .clk     (osc_clk),
    .rst_n   (rst_int_n),
    .cnt     (cnt),
    .ctrl    (ctrl),
    .clk_out (clk_out)
  );

  assert_prohibited_low_R6: assert property (@(posedge osc_clk) disable iff (!rst_int_n)
    ((ctrl.code < CODE_W'(CODE_BASE)) || (ctrl.code > CODE_W'(CODE_BASE + STAGES - 1))) |-> !clk_out);

  assert_reset_quiet_R1: assert property (@(posedge osc_clk) disable iff (!rst_n)
    $rose(rst_int_n) |-> (!clk_out && bus_rdata == '0 || bus_addr != CTRL_ADDR));

endmodule

// File: tb/test_clkout_divider.sv
`timescale 1ns/1ps
module test_clkout_divider;

  localparam logic [15:0] CTRL = 16'hFF40;
  localparam int NVEC = 10;
  localparam logic [4:0] VEC [NVEC] = '{
    5'b1_0101, 5'b0_0101, 5'b1_0110, 5'b0_0111, 5'b1_1000,
    5'b0_1001, 5'b1_1010, 5'b0_1100, 5'b1_1100, 5'b0_1011
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_full = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        clk_out;

  int checks = 0;
  int fails = 0;
  int rise_count = 0;
  int hi_run = 0;
  int lo_run = 0;
  int last_high = 0;
  int last_low = 0;
  logic prev_out = 1'b0;

  always #10 clk = ~clk;

  clkout_divider i_clkout_divider (
    .osc_clk   (clk),
    .rst_n     (rst_n),
    .mode_full (mode_full),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .clk_out   (clk_out)
  );

  always @(negedge clk) begin
    if (clk_out) begin
      if (!prev_out) begin
        rise_count = rise_count + 1;
        last_low = lo_run;
        hi_run = 1;
      end else begin
        hi_run = hi_run + 1;
      end
    end else begin
      if (prev_out) begin
        last_high = hi_run;
        lo_run = 1;
      end else begin
        lo_run = lo_run + 1;
      end
    end
    prev_out = clk_out;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_rises(input int n, input string req);
    int target = rise_count + n;
    int waited = 0;
    while (rise_count < target && waited < 3000) begin
      @(posedge clk); #1;
      waited++;
    end
    check({req, " rise seen"}, int'(rise_count >= target), 1);
  endtask

  task automatic wait_cycles(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int exp;
    int base;

    wait_cycles(3);
    rst_n = 1'b1;
    wait_cycles(6);

    // R1: reset state
    bus_read(CTRL, rd);
    check("R1 register after reset", rd, 8'h00);
    check("R1 clk_out after reset", clk_out, 0);

    // R2 / R3: register access
    bus_write(CTRL, 8'h08);
    bus_read(CTRL, rd);
    check("R2 readback", rd, 8'h08);
    bus_write(16'hFF41, 8'h8C);
    bus_read(CTRL, rd);
    check("R2 foreign write ignored", rd, 8'h08);
    bus_read(16'hFF41, rd);
    check("R2 foreign read zero", rd, 8'h00);
    bus_write(CTRL, 8'h75);
    bus_read(CTRL, rd);
    check("R3 reserved bits read zero", rd, 8'h05);

    // R4 / R5 / R8: vector table of mode and ratio code
    for (int i = 0; i < NVEC; i++) begin
      logic m;
      logic [3:0] c;
      m = VEC[i][4];
      c = VEC[i][3:0];
      exp = (1 << (c - 5)) * (m ? 1 : 2);
      bus_write(CTRL, {4'b0000, c});
      wait_cycles(2 * exp + 4);
      mode_full = m;
      bus_write(CTRL, {4'b1000, c});
      wait_rises(1, "R5");
      while (clk_out) begin
        @(posedge clk); #1;
      end
      @(negedge clk); #1;
      check($sformatf("R8 first pulse full, code %0d mode %0d", c, m), last_high, exp);
      wait_rises(2, "R5");
      check($sformatf("R5 R4 high phase, code %0d mode %0d", c, m), last_high, exp);
      check($sformatf("R5 R4 low phase, code %0d mode %0d", c, m), last_low, exp);
    end

    // R8: disable inside a high phase keeps the pulse full length
    mode_full = 1'b1;
    bus_write(CTRL, 8'h08);
    wait_cycles(20);
    bus_write(CTRL, 8'h88);
    wait_rises(2, "R8");
    wait_cycles(1);
    bus_write(CTRL, 8'h08);
    while (clk_out) begin
      @(posedge clk); #1;
    end
    @(negedge clk); #1;
    check("R8 last pulse full length", last_high, 8);

    // R7: disabled output stays low
    base = rise_count;
    wait_cycles(60);
    check("R7 no rise while disabled", rise_count - base, 0);
    check("R7 output low while disabled", clk_out, 0);

    // R6: prohibited codes with enable set
    bus_write(CTRL, 8'h0D);
    bus_write(CTRL, 8'h8D);
    base = rise_count;
    wait_cycles(600);
    check("R6 code 13 no rise", rise_count - base, 0);
    bus_read(CTRL, rd);
    check("R6 code 13 readback", rd, 8'h8D);
    bus_write(CTRL, 8'h00);
    bus_write(CTRL, 8'h84);
    base = rise_count;
    wait_cycles(100);
    check("R6 code 4 no rise", rise_count - base, 0);
    check("R6 output low", clk_out, 0);

    summary();
    $finish;
  end

endmodule